// File: doc/BRIEF.md
# Masked-write PHY control register bank

This block is a slave register bank for a four-lane serial display transmitter PHY. Twelve 16-bit control words drive the PHY's power, PLL, rate, SSC and per-lane drive settings. Two read-only status words report PLL lock. A bus master reaches the bank through a simple synchronous port: a byte address, 32-bit write data, a write strobe and combinational read data.

Each 32-bit write carries its own bit-enable mask. Bits 31:16 of the write data select which of bits 15:0 are written. Firmware can therefore change one field, such as one lane's emphasis, in a single write, with no read-modify-write and no race against other fields in the same word.

The bank has no sequencing state. An address decoder sorts each access into one of four read sources: none, control, status 0 and status 1. Read data is a pure multiplexer. Each control word is a masked register with its own reset value.

Top module: `phy_ctl_bank`

## Requirements
- R1: After reset, control word 0 reads 0x0FF1: all four lane-idle bits, all four lane power-down bits and the PLL power-down bit are set. Every other control word reads 0.
- R2: A write to a control word (word index = address bits 7:2, address bits 1:0 zero, index 0 to 11) sets bit n to write-data bit n exactly when write-data bit n+16 is 1. All other bits keep their values.
- R3: A write whose bits 31:16 are all zero leaves the addressed word unchanged.
- R4: Read data bits 31:16 are always zero, and bits 15:0 carry the selected 16-bit word.
- R5: The word at offset 0x30 reads the PLL-ready input in bit 0, with all other bits zero. The word at 0x34 reads zero.
- R6: Writes to 0x30, to 0x34, to offsets 0x38 and above, and to non-word-aligned addresses change no control word.
- R7: Reads of offsets 0x38 and above, and of non-word-aligned addresses, return zero.
- R8: Control word 0 drives lane idle from bits 11:8, lane power-down from bits 7:4, the IDDQ enable from bit 1 and PLL power-down from bit 0. Lane i uses bit i of each lane field.
- R9: Control word 1 bits 14:0 drive the PLL divider. Control word 2 drives termination from bits 10:8, the rate code from bits 5:4 and the reference divider from bits 3:0.
- R10: For each lane i, emphasis comes from word 3 bits 4i+3:4i, amplitude from word 4 bits 4i+2:4i, and amplitude scale from word 5 bits 2i+1:2i. The TX mode comes from word 5 bits 9:8.
- R11: Control word 6 drives SSC depth from bits 15:12, SSC enable from bit 11 and SSC count from bits 9:0.
- R12: Control words 7 to 11 appear unchanged on an 80-bit output, with word 7 in bits 15:0 and each following word in the next 16 bits.
- R13: A write takes effect at the clock edge on which the write strobe is sampled high, and is visible on read data and outputs from that edge on. With the strobe low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Bit enables in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read data for bus_addr |
| pll_ready | input | 1 | PLL lock status from the PHY |
| lane_idle | output | 4 | Per-lane transmitter idle |
| lane_pwrdn | output | 4 | Per-lane transmitter power-down |
| iddq_en | output | 1 | Quiescent-current test enable |
| pll_pwrdn | output | 1 | PLL power-down |
| pll_div | output | 15 | PLL feedback divider |
| tx_term | output | 3 | Transmitter termination code |
| rate_sel | output | 2 | Link rate code |
| ref_div | output | 4 | Reference divider |
| lane_emph | output | 16 | Emphasis, 4 bits per lane |
| lane_amp | output | 12 | Amplitude, 3 bits per lane |
| lane_amp_scale | output | 8 | Amplitude scale, 2 bits per lane |
| tx_mode | output | 2 | Transmitter mode |
| ssc_depth | output | 4 | Spread-spectrum depth |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssc_count | output | 10 | Spread-spectrum count |
| misc_words | output | 80 | Raw control words 7 to 11 |

## Verification
Read data is combinational from the address, so a read result is due in the same cycle the address is applied. The bench drives the address on the falling edge and samples one nanosecond later, well before the next rising edge. A write lands on the rising edge that samples the strobe high. The bench raises the strobe on a falling edge and drops it on the next one, then reads back and compares every field output. At that point exactly one register stage separates stimulus from result. The bench keeps a masked-update model of all twelve words and compares every field and every read offset against it.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    localparam int NUM_CTL    = 12;
    localparam int REG_W      = 16;
    localparam int BUS_W      = 2 * REG_W;
    localparam int NUM_LANES  = 4;
    localparam int CTL_IDX_W  = $clog2(NUM_CTL);
    localparam int STAT0_IDX  = NUM_CTL;
    localparam int STAT1_IDX  = NUM_CTL + 1;
    localparam int RAW_FIRST  = 7;
    localparam int RAW_COUNT  = NUM_CTL - RAW_FIRST;

    // word 0 field placement
    localparam int IDLE_LSB   = 8;
    localparam int PWRDN_LSB  = 4;
    localparam int IDDQ_BIT   = 1;
    localparam int PLLPD_BIT  = 0;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_CTL   = 2'd1,
        SRC_STAT0 = 2'd2,
        SRC_STAT1 = 2'd3
    } rd_src_e;

    function automatic logic [REG_W-1:0] ctl_rst(input int idx);
        logic [REG_W-1:0] v;
        v = '0;
        if (idx == 0) begin
            v[IDLE_LSB +: NUM_LANES]  = '1;
            v[PWRDN_LSB +: NUM_LANES] = '1;
            v[PLLPD_BIT]              = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/phy_ctl_decode.sv
module phy_ctl_decode
    import phy_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 we,
    output logic [NUM_CTL-1:0]   ctl_we,
    output logic [CTL_IDX_W-1:0] ctl_idx,
    output rd_src_e              rd_src
);
    localparam int IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] widx;

    assign aligned = (addr[1:0] == 2'b00);
    assign widx    = addr[ADDR_W-1:2];
    assign ctl_idx = widx[CTL_IDX_W-1:0];

    for (genvar i = 0; i < NUM_CTL; i++) begin : g_we
        assign ctl_we[i] = we && aligned && (widx == IDX_W'(i));
    end

    always_comb begin
        rd_src = SRC_NONE;
        if (aligned) begin
            if (widx < IDX_W'(NUM_CTL))
                rd_src = SRC_CTL;
            else if (widx == IDX_W'(STAT0_IDX))
                rd_src = SRC_STAT0;
            else if (widx == IDX_W'(STAT1_IDX))
                rd_src = SRC_STAT1;
        end
    end
endmodule

// File: rtl/phy_ctl_wreg.sv
module phy_ctl_wreg #(
    parameter int            W   = 16,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] wr_mask,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= RST;
        else if (wr_en)
            q <= (q & ~wr_mask) | (wr_data & wr_mask);
    end
endmodule

// File: rtl/phy_ctl_rdmux.sv
module phy_ctl_rdmux
    import phy_ctl_pkg::*;
(
    input  rd_src_e                         rd_src,
    input  logic [CTL_IDX_W-1:0]            ctl_idx,
    input  logic [NUM_CTL-1:0][REG_W-1:0]   words,
    input  logic                            pll_ready,
    output logic [BUS_W-1:0]                rdata
);
    logic [REG_W-1:0] low;

    always_comb begin
        low = '0;
        unique case (rd_src)
            SRC_CTL:   low = words[ctl_idx];
            SRC_STAT0: low = {{(REG_W-1){1'b0}}, pll_ready};
            SRC_STAT1: low = '0;
            SRC_NONE:  low = '0;
            default:   low = '0;
        endcase
    end

    assign rdata = {{(BUS_W-REG_W){1'b0}}, low};
endmodule

// File: rtl/phy_ctl_bank.sv
module phy_ctl_bank
    import phy_ctl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_we,
    input  logic [BUS_W-1:0]              bus_wdata,
    output logic [BUS_W-1:0]              bus_rdata,
    input  logic                          pll_ready,
    output logic [NUM_LANES-1:0]          lane_idle,
    output logic [NUM_LANES-1:0]          lane_pwrdn,
    output logic                          iddq_en,
    output logic                          pll_pwrdn,
    output logic [14:0]                   pll_div,
    output logic [2:0]                    tx_term,
    output logic [1:0]                    rate_sel,
    output logic [3:0]                    ref_div,
    output logic [4*NUM_LANES-1:0]        lane_emph,
    output logic [3*NUM_LANES-1:0]        lane_amp,
    output logic [2*NUM_LANES-1:0]        lane_amp_scale,
    output logic [1:0]                    tx_mode,
    output logic [3:0]                    ssc_depth,
    output logic                          ssc_en,
    output logic [9:0]                    ssc_count,
    output logic [RAW_COUNT*REG_W-1:0]    misc_words
);
    logic [NUM_CTL-1:0]             ctl_we;
    logic [CTL_IDX_W-1:0]           ctl_idx;
    rd_src_e                        rd_src;
    logic [NUM_CTL-1:0][REG_W-1:0]  ctl_q;

    phy_ctl_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .ctl_we  (ctl_we),
        .ctl_idx (ctl_idx),
        .rd_src  (rd_src)
    );

    for (genvar i = 0; i < NUM_CTL; i++) begin : g_reg
        phy_ctl_wreg #(.W(REG_W), .RST(ctl_rst(i))) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (ctl_we[i]),
            .wr_data (bus_wdata[REG_W-1:0]),
            .wr_mask (bus_wdata[BUS_W-1:REG_W]),
            .q       (ctl_q[i])
        );
    end

    phy_ctl_rdmux u_rd (
        .rd_src    (rd_src),
        .ctl_idx   (ctl_idx),
        .words     (ctl_q),
        .pll_ready (pll_ready),
        .rdata     (bus_rdata)
    );

    // word 0: power and idle
    assign lane_idle  = ctl_q[0][IDLE_LSB +: NUM_LANES];
    assign lane_pwrdn = ctl_q[0][PWRDN_LSB +: NUM_LANES];
    assign iddq_en    = ctl_q[0][IDDQ_BIT];
    assign pll_pwrdn  = ctl_q[0][PLLPD_BIT];

    // words 1 and 2: PLL and rate
    assign pll_div    = ctl_q[1][14:0];
    assign tx_term    = ctl_q[2][10:8];
    assign rate_sel   = ctl_q[2][5:4];
    assign ref_div    = ctl_q[2][3:0];

    // words 3 to 5: per-lane drive
    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign lane_emph[4*l +: 4]      = ctl_q[3][4*l +: 4];
        assign lane_amp[3*l +: 3]       = ctl_q[4][4*l +: 3];
        assign lane_amp_scale[2*l +: 2] = ctl_q[5][2*l +: 2];
    end
    assign tx_mode    = ctl_q[5][9:8];

    // word 6: spread spectrum
    assign ssc_depth  = ctl_q[6][15:12];
    assign ssc_en     = ctl_q[6][11];
    assign ssc_count  = ctl_q[6][9:0];

    // words 7 to 11: raw
    for (genvar k = 0; k < RAW_COUNT; k++) begin : g_raw
        assign misc_words[REG_W*k +: REG_W] = ctl_q[RAW_FIRST + k];
    end
endmodule

// File: rtl/phy_ctl_bank_chk.sv
module phy_ctl_bank_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              pll_ready,
    input logic [14:0]       pll_div,
    input logic [15:0]       lane_emph,
    input logic              ssc_en
);
    assert_rdata_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0);

    assert_status_pll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(8'h30)) |-> (bus_rdata == {31'b0, pll_ready}));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= ADDR_W'(8'h38)) |-> (bus_rdata == 32'h0));

    assert_masked_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h18) && bus_wdata[27]) |=> (ssc_en == $past(bus_wdata[11])));

    assert_masked_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h18) && !bus_wdata[27]) |=> $stable(ssc_en));

    assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(8'h04) && bus_wdata[31:16] == 16'h0) |=> $stable(pll_div));

    assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr >= ADDR_W'(8'h30)) |=> ($stable(pll_div) && $stable(lane_emph) && $stable(ssc_en)));

    assert_idle_bus_stable_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pll_div) && $stable(lane_emph) && $stable(ssc_en)));
endmodule

bind phy_ctl_bank phy_ctl_bank_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pll_ready (pll_ready),
    .pll_div   (pll_div),
    .lane_emph (lane_emph),
    .ssc_en    (ssc_en)
);

// File: tb/phy_ctl_bank_tb.sv
module phy_ctl_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_ready = 1'b0;
    logic [3:0]  lane_idle, lane_pwrdn;
    logic        iddq_en, pll_pwrdn;
    logic [14:0] pll_div;
    logic [2:0]  tx_term;
    logic [1:0]  rate_sel;
    logic [3:0]  ref_div;
    logic [15:0] lane_emph;
    logic [11:0] lane_amp;
    logic [7:0]  lane_amp_scale;
    logic [1:0]  tx_mode;
    logic [3:0]  ssc_depth;
    logic        ssc_en;
    logic [9:0]  ssc_count;
    logic [79:0] misc_words;

    int total = 0;
    int bad = 0;
    logic [15:0] mdl [12];

    phy_ctl_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_ready(pll_ready),
        .lane_idle(lane_idle), .lane_pwrdn(lane_pwrdn), .iddq_en(iddq_en),
        .pll_pwrdn(pll_pwrdn), .pll_div(pll_div), .tx_term(tx_term),
        .rate_sel(rate_sel), .ref_div(ref_div), .lane_emph(lane_emph),
        .lane_amp(lane_amp), .lane_amp_scale(lane_amp_scale), .tx_mode(tx_mode),
        .ssc_depth(ssc_depth), .ssc_en(ssc_en), .ssc_count(ssc_count),
        .misc_words(misc_words)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] mask, input logic [15:0] data);
        @(negedge clk);
        bus_addr = a; bus_wdata = {mask, data}; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (a[1:0] == 2'b00 && a[7:2] < 6'd12)
            mdl[a[7:2]] = (mdl[a[7:2]] & ~mask) | (data & mask);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic chk_fields();
        logic [15:0] w0, w4, w5;
        w0 = mdl[0]; w4 = mdl[4]; w5 = mdl[5];
        chk("R8 word0 fields", {lane_idle, lane_pwrdn, iddq_en, pll_pwrdn},
            {w0[11:8], w0[7:4], w0[1], w0[0]});
        chk("R9 pll/rate fields", {pll_div, tx_term, rate_sel, ref_div},
            {mdl[1][14:0], mdl[2][10:8], mdl[2][5:4], mdl[2][3:0]});
        chk("R10 lane drive fields", {lane_emph, lane_amp, lane_amp_scale, tx_mode},
            {mdl[3], w4[14:12], w4[10:8], w4[6:4], w4[2:0], w5[7:0], w5[9:8]});
        chk("R11 ssc fields", {ssc_depth, ssc_en, ssc_count},
            {mdl[6][15:12], mdl[6][11], mdl[6][9:0]});
        chk("R12 raw words", misc_words, {mdl[11], mdl[10], mdl[9], mdl[8], mdl[7]});
    endtask

    task automatic chk_all_words(input string tag);
        logic [31:0] d;
        for (int i = 0; i < 12; i++) begin
            rd(8'(i * 4), d);
            chk(tag, d, {16'h0, mdl[i]});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 12; i++) mdl[i] = (i == 0) ? 16'h0FF1 : 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_all_words("R1 reset word");
        chk_fields();

        // R2 / R3 / R13 sweep over every control word
        for (int r = 0; r < 12; r++) begin
            for (int p = 0; p < 6; p++) begin
                logic [15:0] m, dv;
                dv = 16'hA5C3 ^ 16'(p * 16'h1111) ^ 16'(r << 3);
                case (p)
                    0: m = 16'hFFFF;
                    1: m = 16'h0000;
                    2: m = 16'h00FF;
                    3: m = 16'hFF00;
                    4: m = 16'(1 << r);
                    default: m = 16'h5A5A;
                endcase
                wr(8'(r * 4), m, dv);
                rd(8'(r * 4), d);
                if (p == 1) chk("R3 zero mask keeps word", d, {16'h0, mdl[r]});
                else        chk("R2 masked write readback", d, {16'h0, mdl[r]});
                chk("R4 upper half zero", d[31:16], 16'h0);
                chk_fields();
            end
        end

        // single-field update on word 6 and word 0
        wr(8'h18, 16'h0800, 16'h0800);
        chk("R11 ssc enable only", {ssc_en}, 1'b1);
        wr(8'h00, 16'h0F00, 16'h0000);
        chk("R8 lane idle cleared", {lane_idle}, 4'h0);
        chk_fields();

        // R6 ignored writes
        wr(8'h30, 16'hFFFF, 16'hFFFF);
        wr(8'h34, 16'hFFFF, 16'h1234);
        wr(8'h38, 16'hFFFF, 16'h0000);
        wr(8'hFC, 16'hFFFF, 16'h0000);
        wr(8'h05, 16'hFFFF, 16'h0000);
        wr(8'h02, 16'hFFFF, 16'h0000);
        chk_all_words("R6 ignored writes");
        chk_fields();

        // R13 no strobe
        @(negedge clk);
        bus_addr = 8'h04; bus_wdata = 32'hFFFF_0000; bus_we = 1'b0;
        @(negedge clk);
        chk_all_words("R13 no strobe");

        // R5 status
        pll_ready = 1'b1;
        rd(8'h30, d); chk("R5 status0 ready", d, 32'h1);
        pll_ready = 1'b0;
        rd(8'h30, d); chk("R5 status0 not ready", d, 32'h0);
        pll_ready = 1'b1;
        rd(8'h34, d); chk("R5 status1 zero", d, 32'h0);

        // R7 unmapped and misaligned reads
        for (int a = 14; a < 64; a++) begin
            rd(8'(a * 4), d);
            chk("R7 unmapped read", d, 32'h0);
        end
        for (int a = 0; a < 12; a++) begin
            rd(8'(a * 4 + 1 + (a % 3)), d);
            chk("R7 misaligned read", d, 32'h0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule